// File: doc/BRIEF.md
# Two-Cycle 16-Bit Instruction Fetch Unit

This block assembles 16-bit instruction words from a byte-wide program memory of 256 locations. An internal address counter walks the memory. Each fetch takes two clock cycles. In the first cycle the byte at the even counter value goes into the even byte lane. In the second cycle the byte at the following odd value goes into the odd byte lane. The two lanes drive the 16-bit instruction bus. A one-cycle valid strobe marks the cycle after the odd byte has been captured.

Programs are written into the memory through a write port that works only while the load input is high. During a load the write port takes over the memory address, and fetching is paused: the counter and the byte lanes hold their values. The program-counter enable output is high in exactly those cycles where the counter steps, so a downstream sequencer can follow the fetch position.

Top module: `ifetch16`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) sets fetch_addr to 0, clears both byte lanes (instr = 16'h0000) and instr_valid, and abandons any fetch in progress. pc_en is 0 while rst is high.
- R2: A byte is written to memory address wr_addr at a rising edge only when load_en and wr_en are both high. wr_en with load_en low leaves memory unchanged.
- R3: A completed fetch that starts at even address A presents the byte from A on instr[15:8] and the byte from A+1 on instr[7:0].
- R4: With fetch_req sampled high at edge N while idle and not loading, the even byte is captured at edge N and the odd byte at edge N+1. instr_valid is high for exactly the one cycle after edge N+1.
- R5: instr holds its value from the completion of a fetch until the even byte of the next fetch is captured. instr[7:0] holds until the next odd capture.
- R6: pc_en is high exactly in the cycles where fetch_addr advances by one at the next edge. A fetch advances fetch_addr by exactly two, and instr_valid is only seen with an even fetch_addr.
- R7: fetch_addr wraps from 255 to 0. A fetch at address 254 returns bytes 254 and 255 and leaves fetch_addr at 0.
- R8: While load_en is high, fetch_req is ignored, pc_en is 0, and fetch_addr, the byte lanes and a half-finished fetch are all held. Once load_en falls, a half-finished fetch completes on the next edge using the current memory contents.
- R9: With fetch_req held high, a new word completes every two cycles from consecutive even addresses, and instr_valid alternates high and low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Program-load mode. Pauses fetching and gives the write port the memory address |
| wr_en | input | 1 | Write strobe, honoured only in load mode |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data byte |
| fetch_req | input | 1 | Request one 16-bit fetch, sampled while idle |
| pc_en | output | 1 | High in cycles where the address counter advances |
| fetch_addr | output | 8 | Current address counter value |
| instr | output | 16 | Instruction bus: even byte [15:8], odd byte [7:0] |
| instr_valid | output | 1 | One-cycle strobe after a word completes |

## Verification
The bench goes after the edges of the two-phase fetch. It checks a wrap at address 254, which a counter without modulo wrap or with an off-by-one lane select would return from the wrong bytes. It raises a load in the middle of a fetch and rewrites the pending odd byte: a design that keeps fetching during load would move fetch_addr or complete early, and one that latched the odd byte too soon would return the stale value. It makes a write with load mode low, which a design with a loose write enable would store, and it holds the request high to confirm the two-cycle cadence and the single-cycle valid pulse. It also asserts reset mid-fetch, where a design that keeps a stale phase would emit a spurious valid.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

   // Fetch sequencing: idle/even-capture phase, then odd-capture phase
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_ODD  = 1'b1
   } fetch_phase_e;

   // Number of byte lanes needed to build a word of the given width
   function automatic int lanes_for(input int word_w, input int byte_w);
      return (word_w + byte_w - 1) / byte_w;
   endfunction

endpackage

// File: rtl/fetch_ram.sv
module fetch_ram #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem_q[addr] <= wdata;
      end
   end

   // Combinational read: the byte is captured by the lane register at the edge
   assign rdata = mem_q[addr];

   // R2
   ram_write_chk: assert property (@(posedge clk)
      we |=> (mem_q[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/fetch_counter.sv
module fetch_counter #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   output logic [ADDR_W-1:0] cnt
);
   logic [ADDR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= cnt_q + 1'b1;   // natural modulo wrap
      end
   end

   assign cnt = cnt_q;

   // R1
   cnt_reset_chk: assert property (@(posedge clk)
      rst |=> (cnt_q == '0));

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      adv |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R8
   cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(cnt_q));

endmodule

// File: rtl/byte_lanes.sv
module byte_lanes #(
   parameter int BYTE_W    = 8,
   parameter int LANES     = 2,
   parameter bit EVEN_HIGH = 1'b1,
   localparam int SEL_W    = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int WORD_W   = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap,
   input  logic [SEL_W-1:0]  sel,
   input  logic [BYTE_W-1:0] din,
   output logic [WORD_W-1:0] word
);
   logic [BYTE_W-1:0] lane_q [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst) begin
            lane_q[i] <= '0;
         end else if (cap && (sel == SEL_W'(i))) begin
            lane_q[i] <= din;
         end
      end

      if (EVEN_HIGH) begin : g_hi_first
         assign word[(LANES-1-i)*BYTE_W +: BYTE_W] = lane_q[i];
      end else begin : g_lo_first
         assign word[i*BYTE_W +: BYTE_W] = lane_q[i];
      end
   end

endmodule

// File: rtl/ifetch16.sv
module ifetch16
   import ifetch_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int WORD_W    = 16,
   parameter bit EVEN_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              fetch_req,
   output logic              pc_en,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [WORD_W-1:0] instr,
   output logic              instr_valid
);
   localparam int LANES = lanes_for(WORD_W, BYTE_W);
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

   // Elaboration-time parameter checks
   if (LANES != 2) begin : g_bad_lanes
      $error("ifetch16: WORD_W must be exactly two bytes wide");
   end
   if (LANES * BYTE_W != WORD_W) begin : g_bad_word
      $error("ifetch16: WORD_W must be a multiple of BYTE_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ifetch16: ADDR_W must be at least 2");
   end

   fetch_phase_e      phase_q;
   logic              start_fetch;
   logic              finish_fetch;
   logic              adv;
   logic              valid_q;
   logic [ADDR_W-1:0] cnt;
   logic [ADDR_W-1:0] ram_addr;
   logic [BYTE_W-1:0] ram_rdata;

   // Fetch control: the request is taken only while idle and not loading
   assign start_fetch  = (phase_q == PH_IDLE) && fetch_req && !load_en;
   assign finish_fetch = (phase_q == PH_ODD) && !load_en;
   assign adv          = start_fetch || finish_fetch;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         valid_q <= 1'b0;
      end else begin
         valid_q <= finish_fetch;
         if (start_fetch) begin
            phase_q <= PH_ODD;
         end else if (finish_fetch) begin
            phase_q <= PH_IDLE;
         end
      end
   end

   // Load mode hands the memory address to the write port
   assign ram_addr = load_en ? wr_addr : cnt;

   fetch_ram #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W)
   ) u_ram (
      .clk   (clk),
      .we    (load_en && wr_en),
      .addr  (ram_addr),
      .wdata (wr_data),
      .rdata (ram_rdata)
   );

   fetch_counter #(
      .ADDR_W (ADDR_W)
   ) u_cnt (
      .clk (clk),
      .rst (rst),
      .adv (adv && !rst),
      .cnt (cnt)
   );

   byte_lanes #(
      .BYTE_W    (BYTE_W),
      .LANES     (LANES),
      .EVEN_HIGH (EVEN_HIGH)
   ) u_lanes (
      .clk  (clk),
      .rst  (rst),
      .cap  (adv),
      .sel  (cnt[SEL_W-1:0]),
      .din  (ram_rdata),
      .word (instr)
   );

   assign pc_en       = adv && !rst;
   assign fetch_addr  = cnt;
   assign instr_valid = valid_q;

   // R4
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      instr_valid |=> !instr_valid);

   // R6
   valid_even_chk: assert property (@(posedge clk) disable iff (rst)
      instr_valid |-> (fetch_addr[0] == 1'b0));

   // R8
   load_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
      load_en |-> !pc_en);

   // R5
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !pc_en |=> $stable(instr));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!instr_valid && (instr == '0)));

endmodule

// File: tb/ifetch16_bench.sv
module ifetch16_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        load_en;
   logic        wr_en;
   logic [7:0]  wr_addr;
   logic [7:0]  wr_data;
   logic        fetch_req;
   logic        pc_en;
   logic [7:0]  fetch_addr;
   logic [15:0] instr;
   logic        instr_valid;

   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   logic [7:0] mdl [256];
   logic [7:0] exp_pc;

   // Program table: word k lives at addresses 2k (high byte) and 2k+1 (low byte)
   localparam int NPROG = 8;
   localparam logic [15:0] PROG [NPROG] = '{
      16'h0000, 16'hFFFF, 16'hA55A, 16'h0180,
      16'h7F01, 16'h1234, 16'hC3E7, 16'h8001
   };

   always #4 clk = ~clk;   // 125 MHz

   ifetch16 u_ifetch16 (
      .clk         (clk),
      .rst         (rst),
      .load_en     (load_en),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .fetch_req   (fetch_req),
      .pc_en       (pc_en),
      .fetch_addr  (fetch_addr),
      .instr       (instr),
      .instr_valid (instr_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put_byte(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      load_en = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
      mdl[a] = d;
      @(negedge clk);
      wr_en = 1'b0; load_en = 1'b0;
   endtask

   // Single fetch from idle, checking every cycle of it; called at a negedge
   task automatic one_fetch(input string req);
      logic [15:0] w;
      w = {mdl[exp_pc], mdl[exp_pc + 8'd1]};
      fetch_req = 1'b1;
      #1 chk({req, " R6 pc_en on start"}, pc_en, 1'b1);
      @(negedge clk);
      fetch_req = 1'b0;
      #1;
      chk({req, " R4 no valid after even"}, instr_valid, 1'b0);
      chk({req, " R6 addr after even"}, fetch_addr, exp_pc + 8'd1);
      chk({req, " R6 pc_en on finish"}, pc_en, 1'b1);
      @(negedge clk);
      chk({req, " R3 word"}, instr, w);
      chk({req, " R4 valid"}, instr_valid, 1'b1);
      exp_pc = exp_pc + 8'd2;
      chk({req, " R6 addr step two"}, fetch_addr, exp_pc);
      @(negedge clk);
      chk({req, " R4 valid one cycle"}, instr_valid, 1'b0);
      chk({req, " R5 word held"}, instr, w);
      chk({req, " R6 pc_en idle"}, pc_en, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; load_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; fetch_req = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 addr", fetch_addr, 8'd0);
      chk("R1 instr", instr, 16'h0000);
      chk("R1 valid", instr_valid, 1'b0);
      chk("R1 pc_en", pc_en, 1'b0);
      rst = 1'b0;

      // Fill memory with a computed pattern, then the program table
      for (int a = 0; a < 256; a++) put_byte(8'(a), 8'(a * 7 + 3) ^ 8'h5A);
      for (int k = 0; k < NPROG; k++) begin
         put_byte(8'(2 * k), PROG[k][15:8]);
         put_byte(8'(2 * k + 1), PROG[k][7:0]);
      end
      exp_pc = 8'd0;

      // Table walk: R3 R4 R5 R6
      @(negedge clk);
      for (int k = 0; k < NPROG; k++) begin
         chk("R3 table entry", {mdl[exp_pc], mdl[exp_pc + 8'd1]}, PROG[k]);
         one_fetch("table");
      end

      // R2: write without load mode is ignored
      load_en = 1'b0; wr_en = 1'b1; wr_addr = exp_pc; wr_data = ~mdl[exp_pc];
      @(negedge clk);
      wr_en = 1'b0;
      chk("R2 no fetch during stray write", fetch_addr, exp_pc);
      one_fetch("R2 stray write ignored");

      // R8: load during a fetch, rewriting the pending odd byte
      fetch_req = 1'b1;
      @(negedge clk);
      fetch_req = 1'b0;
      load_en = 1'b1; wr_en = 1'b1; wr_addr = exp_pc + 8'd1; wr_data = 8'h3C;
      mdl[exp_pc + 8'd1] = 8'h3C;
      #1 chk("R8 pc_en low in load", pc_en, 1'b0);
      @(negedge clk);
      wr_en = 1'b0; fetch_req = 1'b1;
      #1;
      chk("R8 addr held", fetch_addr, exp_pc + 8'd1);
      chk("R8 no valid", instr_valid, 1'b0);
      chk("R8 req ignored", pc_en, 1'b0);
      @(negedge clk);
      chk("R8 addr still held", fetch_addr, exp_pc + 8'd1);
      load_en = 1'b0; fetch_req = 1'b0;
      #1 chk("R8 resume pc_en", pc_en, 1'b1);
      @(negedge clk);
      chk("R8 valid after resume", instr_valid, 1'b1);
      chk("R8 new odd byte", instr, {mdl[exp_pc], 8'h3C});
      exp_pc = exp_pc + 8'd2;
      chk("R8 addr after resume", fetch_addr, exp_pc);
      @(negedge clk);

      // R9 + R7: held request, back to back, across the wrap
      fetch_req = 1'b1;
      for (int k = 0; k < 130; k++) begin
         logic [7:0]  a;
         logic [15:0] w;
         a = exp_pc;
         w = {mdl[a], mdl[a + 8'd1]};
         @(negedge clk);
         chk("R9 valid low between words", instr_valid, 1'b0);
         @(negedge clk);
         chk("R9 valid each two cycles", instr_valid, 1'b1);
         chk("R9 word", instr, w);
         exp_pc = exp_pc + 8'd2;
         chk("R9 addr", fetch_addr, exp_pc);
         if (a == 8'd254) begin
            chk("R7 wrap word", instr, {mdl[254], mdl[255]});
            chk("R7 wrap addr", fetch_addr, 8'd0);
         end
      end
      fetch_req = 1'b0;
      @(negedge clk);
      chk("R9 stop", instr_valid, 1'b0);

      // R1: reset in the middle of a fetch
      fetch_req = 1'b1;
      @(negedge clk);
      fetch_req = 1'b0; rst = 1'b1;
      #1 chk("R1 pc_en in reset", pc_en, 1'b0);
      @(negedge clk);
      chk("R1 mid-fetch addr", fetch_addr, 8'd0);
      chk("R1 mid-fetch instr", instr, 16'h0000);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 no stray valid", instr_valid, 1'b0);
      exp_pc = 8'd0;
      one_fetch("R1 after reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule